// File: doc/BRIEF.md
# Chroma Key Signal Generator

This block turns a stream of 8-bit red, green and blue live-video samples into an 8-bit key value that drives the blend-factor path of a video mixer. The key adds two terms. The first term measures how far blue rises above the stronger of red and green. The second term is the complement of a single colour channel. Three configuration bits remove the first term, remove the second term, or pick which channel the second term uses.

The live pixel also goes on toward the blender's live input. A fourth configuration bit can invert it bitwise on the way. The datapath has two registered stages. The valid flag and the live pixel are delayed to match, so that key and pixel leave together. Configuration is sampled in the same cycle as the pixel it applies to, so it may change from one pixel to the next.

Top module: `chroma_key_gen`

## Requirements
- R1: The blue term equals blue minus the larger of red and green, and it is 0 when that difference would be negative.
- R2: When `cfg_zero_blue` is 1, the blue term is 0.
- R3: The channel term is 255 minus green when `cfg_green_key` is 1, and 255 minus red when it is 0.
- R4: When `cfg_blue_only` is 1, the channel term is 0, so the key depends only on the blue term.
- R5: `out_key` is the sum of the two terms, saturated at 255.
- R6: `out_live_r/g/b` carry the input pixel, bitwise inverted when `cfg_live_inv` was 1 in the pixel's input cycle.
- R7: A pixel accepted with `in_valid` high at clock edge k appears with `out_valid` high after edge k+2. Back-to-back pixels come out on consecutive cycles, each using its own configuration.
- R8: Synchronous reset clears `out_valid`, `out_key` and the live outputs to 0. Cycles without `in_valid` leave `out_key` and the live outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | W | Live red sample |
| in_g | input | W | Live green sample |
| in_b | input | W | Live blue sample |
| cfg_zero_blue | input | 1 | Remove the blue term |
| cfg_blue_only | input | 1 | Remove the channel term |
| cfg_green_key | input | 1 | Channel term uses green (1) or red (0) |
| cfg_live_inv | input | 1 | Invert the live pixel output |
| out_valid | output | 1 | Output qualifier, two cycles after input |
| out_key | output | W | Saturated key value |
| out_live_r | output | W | Delayed live red |
| out_live_g | output | W | Delayed live green |
| out_live_b | output | W | Delayed live blue |

## Verification
Each term is tested on its own, first with the other term removed and then with both terms active. The test pixels put blue above both red and green, and also below one of them, to separate the clamp from wrap-around. Pixels with a dark red or a dark green channel show which channel the green-key bit picks. Sums above 255 and a channel term of exactly 255 exercise saturation. A back-to-back pair with different configurations, followed by idle cycles, checks that configuration follows each pixel and that outputs hold between pixels.

// File: rtl/ck_pkg.sv
package ck_pkg;

    // Number of registered stages between input and output
    localparam int PIPE_DEPTH = 2;

    // Per-pixel configuration that shapes the key value
    typedef struct packed {
        logic zero_blue;   // remove blue-dominance term
        logic blue_only;   // remove complemented-channel term
        logic green_key;   // channel term uses green (1) or red (0)
    } key_cfg_t;

endpackage

// File: rtl/ck_term_stage.sv
module ck_term_stage
    import ck_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_r,
    input  logic [W-1:0] in_g,
    input  logic [W-1:0] in_b,
    input  key_cfg_t     cfg,
    output logic         s1_valid,
    output logic [W-1:0] term_a,
    output logic [W-1:0] term_b
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] rg_max;
    logic [W-1:0] a_next;
    logic [W-1:0] b_next;
    logic [W-1:0] chan;

    always_comb begin
        rg_max = (in_r > in_g) ? in_r : in_g;
        if (cfg.zero_blue || (in_b <= rg_max))
            a_next = '0;
        else
            a_next = in_b - rg_max;
        chan = cfg.green_key ? in_g : in_r;
        b_next = cfg.blue_only ? '0 : (FULL - chan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            term_a   <= '0;
            term_b   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                term_a <= a_next;
                term_b <= b_next;
            end
        end
    end

    AST_TERM_A_BOUND: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (term_a <= $past(in_b)));                        // R1
    AST_ZERO_BLUE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.zero_blue) |=> (term_a == '0));              // R2
    AST_BLUE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.blue_only) |=> (term_b == '0));              // R4

endmodule

// File: rtl/ck_sum_stage.sv
module ck_sum_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s1_valid,
    input  logic [W-1:0] term_a,
    input  logic [W-1:0] term_b,
    output logic         s2_valid,
    output logic [W-1:0] key
);
    logic [W:0]   sum_wide;
    logic [W-1:0] sum_sat;

    always_comb begin
        sum_wide = {1'b0, term_a} + {1'b0, term_b};
        sum_sat  = sum_wide[W] ? {W{1'b1}} : sum_wide[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            key      <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid)
                key <= sum_sat;
        end
    end

    AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> ((key >= $past(term_a)) && (key >= $past(term_b)))); // R5
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(key));                                       // R8

endmodule

// File: rtl/ck_live_delay.sv
module ck_live_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         invert,
    input  logic [W-1:0] in_r,
    input  logic [W-1:0] in_g,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] out_r,
    output logic [W-1:0] out_g,
    output logic [W-1:0] out_b
);
    localparam int PW = 3 * W;

    logic [PW-1:0] pix_in;
    logic [PW-1:0] pipe [DEPTH];
    logic          vld  [DEPTH-1];

    assign pix_in = invert ? ~{in_r, in_g, in_b} : {in_r, in_g, in_b};

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[0] <= '0;
                else if (in_valid)
                    pipe[0] <= pix_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[i] <= '0;
                else if (vld[i-1])
                    pipe[i] <= pipe[i-1];
            end
        end
        if (i < DEPTH - 1) begin : g_vld
            always_ff @(posedge clk) begin
                if (rst)
                    vld[i] <= 1'b0;
                else if (i == 0)
                    vld[i] <= in_valid;
                else
                    vld[i] <= vld[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign {out_r, out_g, out_b} = pipe[DEPTH-1];

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld[DEPTH-2] |=> $stable(pipe[DEPTH-1]));                    // R8

endmodule

// File: rtl/chroma_key_gen.sv
module chroma_key_gen
    import ck_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_r,
    input  logic [W-1:0] in_g,
    input  logic [W-1:0] in_b,
    input  logic         cfg_zero_blue,
    input  logic         cfg_blue_only,
    input  logic         cfg_green_key,
    input  logic         cfg_live_inv,
    output logic         out_valid,
    output logic [W-1:0] out_key,
    output logic [W-1:0] out_live_r,
    output logic [W-1:0] out_live_g,
    output logic [W-1:0] out_live_b
);
    key_cfg_t     kcfg;
    logic         s1_valid;
    logic [W-1:0] term_a;
    logic [W-1:0] term_b;

    assign kcfg = '{zero_blue: cfg_zero_blue,
                    blue_only: cfg_blue_only,
                    green_key: cfg_green_key};

    ck_term_stage #(.W(W)) i_terms (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_r     (in_r),
        .in_g     (in_g),
        .in_b     (in_b),
        .cfg      (kcfg),
        .s1_valid (s1_valid),
        .term_a   (term_a),
        .term_b   (term_b)
    );

    ck_sum_stage #(.W(W)) i_sum (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .term_a   (term_a),
        .term_b   (term_b),
        .s2_valid (out_valid),
        .key      (out_key)
    );

    ck_live_delay #(.W(W), .DEPTH(PIPE_DEPTH)) i_live (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .invert   (cfg_live_inv),
        .in_r     (in_r),
        .in_g     (in_g),
        .in_b     (in_b),
        .out_r    (out_live_r),
        .out_g    (out_live_g),
        .out_b    (out_live_b)
    );

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);                                      // R7
    AST_VALID_FIRST: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);                                       // R7

endmodule

// File: tb/test_chroma_key_gen.sv
`timescale 1ns/1ps
module test_chroma_key_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_r, in_g, in_b;
    logic       zb, bo, gk, li;
    logic       out_valid;
    logic [7:0] out_key, lr, lg, lb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    chroma_key_gen #(.W(8)) i_chroma_key_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .cfg_zero_blue(zb), .cfg_blue_only(bo),
        .cfg_green_key(gk), .cfg_live_inv(li),
        .out_valid(out_valid), .out_key(out_key),
        .out_live_r(lr), .out_live_g(lg), .out_live_b(lb)
    );

    // {zb,bo,gk,li}, r, g, b, expected key (hand computed from R1..R5)
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {4'b0000, 8'd10,  8'd20,  8'd200, 8'd255}, // R5 saturate 180+245
        {4'b0100, 8'd10,  8'd20,  8'd200, 8'd180}, // R4 blue term only
        {4'b0100, 8'd50,  8'd30,  8'd40,  8'd0  }, // R1 clamp, red max
        {4'b1000, 8'd100, 8'd60,  8'd250, 8'd155}, // R2 R3 red channel
        {4'b1010, 8'd100, 8'd60,  8'd250, 8'd195}, // R2 R3 green channel
        {4'b0011, 8'd200, 8'd250, 8'd240, 8'd5  }, // R1 clamp green max, R6
        {4'b0000, 8'd240, 8'd10,  8'd250, 8'd25 }, // R1 R5 small sum
        {4'b1100, 8'd1,   8'd2,   8'd255, 8'd0  }, // R2 R4 both removed
        {4'b0001, 8'd0,   8'd0,   8'd0,   8'd255}, // R3 full channel term, R6
        {4'b0010, 8'd0,   8'd100, 8'd120, 8'd175}, // R1 R3 green key
        {4'b0000, 8'd128, 8'd64,  8'd191, 8'd190}, // R5 no saturation
        {4'b0000, 8'd1,   8'd0,   8'd0,   8'd254}  // R3 red=1
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [35:0] v, input logic vld);
        {zb, bo, gk, li} = v[35:32];
        in_r = v[31:24]; in_g = v[23:16]; in_b = v[15:8];
        in_valid = vld;
    endtask

    task automatic check_out(input logic [35:0] v, input string tag);
        logic [23:0] pix;
        pix = v[34-2] ? ~v[31:8] : v[31:8];
        pix = v[32] ? ~v[31:8] : v[31:8];
        chk({tag, " R7 valid"}, int'(out_valid), 1);
        chk({tag, " R5 key"}, int'(out_key), int'(v[7:0]));
        chk({tag, " R6 live"}, int'({lr, lg, lb}), int'(pix));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(36'h0_FF_FF_FF_00, 1'b0);
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset valid", int'(out_valid), 0);
        chk("R8 reset key", int'(out_key), 0);
        chk("R8 reset live", int'({lr, lg, lb}), 0);
        rst = 1'b0;

        // Table walk: one pixel, then idle, output checked after two edges
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); drive(VEC[i], 1'b1);
            @(negedge clk); in_valid = 1'b0;
            chk("R7 no early valid", int'(out_valid), 0);
            @(negedge clk); check_out(VEC[i], "table");
            @(negedge clk);
            chk("R7 single pulse", int'(out_valid), 0);
        end

        // R8 hold: idle cycles with changing inputs leave outputs unchanged
        drive({4'b0001, 8'd7, 8'd7, 8'd7, 8'd0}, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 hold key", int'(out_key), 254);
        chk("R8 hold live", int'({lr, lg, lb}), int'(24'h010000));

        // R7 back-to-back pixels with different configurations
        @(negedge clk); drive(VEC[3], 1'b1);
        @(negedge clk); drive(VEC[5], 1'b1);
        @(negedge clk); in_valid = 1'b0; check_out(VEC[3], "stream first");
        @(negedge clk); check_out(VEC[5], "stream second");
        @(negedge clk);
        chk("R7 stream end", int'(out_valid), 0);

        // R8 reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset again key", int'(out_key), 0);
        chk("R8 reset again valid", int'(out_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule